// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block computes where the program counter goes when a core enters or leaves its privileged handler mode. When a fault reaches commit, the block records a restart address. It then forms the handler entry point from a handler base value plus a fixed per-fault vector offset. If the fault arrives while the core is in normal mode, it also asks the shadow register bank to swap in.

When a return-from-handler instruction commits, the block redirects fetch to the saved restart address. It can also ask for the shadow bank to be swapped back out. A return attempted outside handler mode is rejected with a fault pulse. Handler mode is encoded in bit 0 of the program counter.

All results are registered. They appear one clock after the commit inputs are presented. The shadow storage itself lives elsewhere: this block only issues the swap requests and tracks which way the bank currently faces.

Top module: `trap_seq`

## Requirements
- R1: After reset, `redirect_valid`, `swap_in`, `swap_out`, `ret_fault` and `swap_err` are 0, `exc_addr` is 0, and the shadow bank is considered swapped out.
- R2: A cycle with `fault_valid` high makes `redirect_valid` high on the next cycle, with `redirect_pc` = `handler_base` + `fault_code` × 128.
- R3: On a fault, `exc_addr` takes `commit_pc`, except when `fault_code` is 0 (interrupt) and `commit_pc[0]` is 1; in that case `exc_addr` keeps its old value.
- R4: For trap-class faults, `fault_code` 1 (handler call) and 2 (arithmetic), the saved value is `commit_pc` + 4.
- R5: `swap_in` pulses on the cycle after a fault exactly when `commit_pc[0]` was 0 at the fault.
- R6: A return (`ret_req` high, `fault_valid` low) with `commit_pc[0]` = 0 pulses `ret_fault` on the next cycle. It gives no redirect, no swap, and leaves `exc_addr` unchanged.
- R7: A return with `commit_pc[0]` = 1 gives `redirect_valid` with `redirect_pc` equal to `exc_addr` as it stood at the return.
- R8: On an accepted return, `swap_out` pulses only when bit 0 of the saved address is 0. Otherwise the bank stays swapped in.
- R9: `swap_err` pulses with a swap request that points the way the bank already faces: swap-in while swapped in, or swap-out while swapped out.
- R10: When `fault_valid` and `ret_req` are high together, the fault is taken and the return is ignored; `ret_fault` stays 0.
- R11: `redirect_valid`, `swap_in`, `swap_out`, `ret_fault` and `swap_err` last one cycle, and are 0 after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit_pc | input | PC_W | PC of the committing instruction; bit 0 set means handler mode |
| fault_valid | input | 1 | A fault is taken this cycle |
| fault_code | input | 3 | Fault number, selects the vector; 0 interrupt, 1 call, 2 arithmetic |
| ret_req | input | 1 | Return-from-handler instruction commits this cycle |
| handler_base | input | PC_W | Base address of the handler vector table |
| redirect_valid | output | 1 | Pulse: `redirect_pc` is a new fetch target |
| redirect_pc | output | PC_W | Redirect target |
| exc_addr | output | PC_W | Saved restart address |
| swap_in | output | 1 | Pulse: request swapping the shadow bank in |
| swap_out | output | 1 | Pulse: request swapping the shadow bank out |
| ret_fault | output | 1 | Pulse: return attempted outside handler mode |
| swap_err | output | 1 | Pulse: swap request agrees with the current bank state |

## Verification
The bench builds the block at its default 32-bit PC width with a 128-byte vector spacing. With a handler base at 0x8001, every vector target keeps bit 0 set, so entry into handler mode can be seen directly on `redirect_pc`. Its sequence reaches the low and high ends of the vector range (codes 0 and 7) and the retained interrupt address. It also covers a return whose saved address keeps the bank swapped in, and swap errors in both directions.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int FC_W = 3;
  typedef enum logic [FC_W-1:0] {
    FC_INTR  = 3'd0,
    FC_CALL  = 3'd1,
    FC_ARITH = 3'd2
  } fault_kind_e;

  function automatic logic is_trap_class(input logic [FC_W-1:0] code);
    return (code == FC_CALL) || (code == FC_ARITH);
  endfunction

  function automatic logic keeps_old_addr(input logic [FC_W-1:0] code, input logic in_handler);
    return (code == FC_INTR) && in_handler;
  endfunction
endpackage

// File: rtl/trap_vector.sv
module trap_vector import trap_seq_pkg::*; #(
  parameter int PC_W      = 32,
  parameter int VEC_ALIGN = 128
) (
  input  logic [PC_W-1:0] base,
  input  logic [FC_W-1:0] code,
  output logic [PC_W-1:0] target
);
  localparam int VEC_SHIFT = $clog2(VEC_ALIGN);

  function automatic logic [PC_W-1:0] vec_target(input logic [PC_W-1:0] b,
                                                 input logic [FC_W-1:0] c);
    return b + (PC_W'(c) << VEC_SHIFT);
  endfunction

  assign target = vec_target(base, code);
endmodule

// File: rtl/exc_addr_reg.sv
module exc_addr_reg import trap_seq_pkg::*; #(
  parameter int PC_W      = 32,
  parameter int INSN_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_fault,
  input  logic [FC_W-1:0] code,
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] saved
);
  function automatic logic [PC_W-1:0] restart_of(input logic [PC_W-1:0] p,
                                                 input logic [FC_W-1:0] c);
    return is_trap_class(c) ? p + PC_W'(INSN_STEP) : p;
  endfunction

  logic load_en;
  assign load_en = take_fault && !keeps_old_addr(code, pc[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved <= '0;
    else if (load_en) saved <= restart_of(pc, code);
  end
endmodule

// File: rtl/shadow_track.sv
module shadow_track (
  input  logic clk,
  input  logic rst_n,
  input  logic want_in,
  input  logic want_out,
  output logic shadow_on,
  output logic err_q
);
  logic clash;
  assign clash = (want_in && shadow_on) || (want_out && !shadow_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_on <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= clash;
      if (want_in)       shadow_on <= 1'b1;
      else if (want_out) shadow_on <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq import trap_seq_pkg::*; #(
  parameter int PC_W      = 32,
  parameter int VEC_ALIGN = 128,
  parameter int INSN_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] commit_pc,
  input  logic            fault_valid,
  input  logic [2:0]      fault_code,
  input  logic            ret_req,
  input  logic [PC_W-1:0] handler_base,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] exc_addr,
  output logic            swap_in,
  output logic            swap_out,
  output logic            ret_fault,
  output logic            swap_err
);
  logic in_handler, take_ret, ret_ok, ret_bad, want_in, want_out, shadow_on;
  logic [PC_W-1:0] vec_pc;

  assign in_handler = commit_pc[0];
  assign take_ret   = ret_req && !fault_valid;
  assign ret_ok     = take_ret && in_handler;
  assign ret_bad    = take_ret && !in_handler;
  assign want_in    = fault_valid && !in_handler;
  assign want_out   = ret_ok && !exc_addr[0];

  trap_vector #(.PC_W(PC_W), .VEC_ALIGN(VEC_ALIGN)) u_vec (
    .base(handler_base), .code(fault_code), .target(vec_pc));

  exc_addr_reg #(.PC_W(PC_W), .INSN_STEP(INSN_STEP)) u_exc (
    .clk(clk), .rst_n(rst_n), .take_fault(fault_valid), .code(fault_code),
    .pc(commit_pc), .saved(exc_addr));

  shadow_track u_shd (
    .clk(clk), .rst_n(rst_n), .want_in(want_in), .want_out(want_out),
    .shadow_on(shadow_on), .err_q(swap_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      swap_in        <= 1'b0;
      swap_out       <= 1'b0;
      ret_fault      <= 1'b0;
    end else begin
      redirect_valid <= fault_valid || ret_ok;
      swap_in        <= want_in;
      swap_out       <= want_out;
      ret_fault      <= ret_bad;
      if (fault_valid) redirect_pc <= vec_pc;
      else if (ret_ok) redirect_pc <= exc_addr;
    end
  end
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] commit_pc,
  input logic            fault_valid,
  input logic [2:0]      fault_code,
  input logic            ret_req,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_pc,
  input logic [PC_W-1:0] exc_addr,
  input logic            swap_in,
  input logic            swap_out,
  input logic            ret_fault,
  input logic            swap_err,
  input logic            shadow_on
);
  assert_intr_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_code == 3'd0 && commit_pc[0]) |=> $stable(exc_addr));

  assert_swap_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !commit_pc[0]) |=> swap_in);

  assert_bad_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !fault_valid && !commit_pc[0]) |=> (ret_fault && !redirect_valid && $stable(exc_addr)));

  assert_ret_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !fault_valid && commit_pc[0]) |=> (redirect_valid && redirect_pc == $past(exc_addr)));

  assert_swap_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !commit_pc[0] && shadow_on) |=> swap_err);

  assert_fault_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && ret_req) |=> !ret_fault);

  assert_one_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({swap_in, swap_out}));
endmodule

bind trap_seq trap_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_pc(commit_pc), .fault_valid(fault_valid),
  .fault_code(fault_code), .ret_req(ret_req), .redirect_valid(redirect_valid),
  .redirect_pc(redirect_pc), .exc_addr(exc_addr), .swap_in(swap_in),
  .swap_out(swap_out), .ret_fault(ret_fault), .swap_err(swap_err),
  .shadow_on(shadow_on));

// File: tb/trap_seq_bench.sv
module trap_seq_bench;
  localparam int PC_W = 32;
  localparam logic [PC_W-1:0] BASE = 32'h0000_8001;

  typedef struct packed {
    logic [31:0] pc;
    logic        flt;
    logic [2:0]  code;
    logic        ret;
    logic        e_rv;
    logic [31:0] e_pc;
    logic [31:0] e_exc;
    logic        e_sin;
    logic        e_sout;
    logic        e_rf;
    logic        e_err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{32'h1000, 1'b1, 3'd3, 1'b0, 1'b1, 32'h8181, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h8181, 1'b0, 3'd0, 1'b1, 1'b1, 32'h1000, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h2000, 1'b1, 3'd1, 1'b0, 1'b1, 32'h8081, 32'h2004, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h8085, 1'b1, 3'd0, 1'b0, 1'b1, 32'h8001, 32'h2004, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h8089, 1'b1, 3'd2, 1'b0, 1'b1, 32'h8101, 32'h808D, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h8101, 1'b0, 3'd0, 1'b1, 1'b1, 32'h808D, 32'h808D, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h3000, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0,    32'h808D, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h4000, 1'b1, 3'd0, 1'b0, 1'b1, 32'h8001, 32'h4000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'h8001, 1'b0, 3'd0, 1'b1, 1'b1, 32'h4000, 32'h4000, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h5000, 1'b1, 3'd7, 1'b1, 1'b1, 32'h8381, 32'h5000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h6000, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0,    32'h5000, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] commit_pc = '0;
  logic fault_valid = 1'b0;
  logic [2:0] fault_code = '0;
  logic ret_req = 1'b0;
  logic [PC_W-1:0] handler_base = BASE;
  logic redirect_valid, swap_in, swap_out, ret_fault, swap_err;
  logic [PC_W-1:0] redirect_pc, exc_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  trap_seq #(.PC_W(PC_W)) u_trap_seq (
    .clk(clk), .rst_n(rst_n), .commit_pc(commit_pc), .fault_valid(fault_valid),
    .fault_code(fault_code), .ret_req(ret_req), .handler_base(handler_base),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .exc_addr(exc_addr),
    .swap_in(swap_in), .swap_out(swap_out), .ret_fault(ret_fault), .swap_err(swap_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input logic flt, input logic [2:0] code,
                      input logic ret);
    @(negedge clk);
    commit_pc = pc; fault_valid = flt; fault_code = code; ret_req = ret;
    @(posedge clk);
    #1ns;
    @(negedge clk);
    fault_valid = 1'b0; ret_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 redirect_valid", 32'(redirect_valid), 0);
    chk("R1 exc_addr", exc_addr, 0);
    chk("R1 swaps", 32'({swap_in, swap_out, ret_fault, swap_err}), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk);
      commit_pc = v.pc; fault_valid = v.flt; fault_code = v.code; ret_req = v.ret;
      @(posedge clk);
      #1ns;
      // R2 R7 R11 redirect pulse; R3 R4 saved address
      chk($sformatf("R2/R7/R11 redirect_valid vec %0d", i), 32'(redirect_valid), 32'(v.e_rv));
      if (v.e_rv) chk($sformatf("R2/R7 redirect_pc vec %0d", i), redirect_pc, v.e_pc);
      chk($sformatf("R3/R4 exc_addr vec %0d", i), exc_addr, v.e_exc);
      chk($sformatf("R5 swap_in vec %0d", i), 32'(swap_in), 32'(v.e_sin));
      chk($sformatf("R8 swap_out vec %0d", i), 32'(swap_out), 32'(v.e_sout));
      chk($sformatf("R6/R10 ret_fault vec %0d", i), 32'(ret_fault), 32'(v.e_rf));
      chk($sformatf("R9 swap_err vec %0d", i), 32'(swap_err), 32'(v.e_err));
    end

    // R9 swap-out while already swapped out, straight after reset
    do_reset();
    step(32'h8001, 1'b0, 3'd0, 1'b1);
    chk("R9 swap_err on swap-out when out", 32'(swap_err), 1);
    chk("R8 swap_out with saved bit0 clear", 32'(swap_out), 1);
    chk("R7 redirect to reset exc_addr", redirect_pc, 0);
    // R11 pulses drop after an idle cycle
    @(posedge clk); #1ns;
    chk("R11 pulses cleared", 32'({redirect_valid, swap_out, swap_err}), 0);
    // R1 reset clears a loaded exc_addr
    step(32'h7000, 1'b1, 3'd4, 1'b0);
    chk("R2 code 4 target", redirect_pc, BASE + 32'h200);
    do_reset();
    chk("R1 exc_addr after reset", exc_addr, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule